// File: doc/BRIEF.md
# Multi-Device DMA Frame Sequencer

This block lets a number of on-board devices share a single host DMA channel. A small map RAM holds a list of local byte addresses. Each entry also carries an end-of-frame flag. When the chosen request source produces a rising edge, the sequencer asks the host for DMA service. It then moves one whole frame back-to-back, at whatever pace the host acknowledges. On each acknowledged cycle it replaces the host address on the local bus with the address from the current map entry, and it strobes the device in the configured direction. It then steps to the next entry.

A frame ends after the entry that carries the end-of-frame flag. If no entry carries the flag, the frame ends after the last map entry. The entry pointer then goes back to the first entry. A request edge that arrives while a frame is still open does not start a second frame. Instead it sets a sticky overrun flag.

Top module: `dfs_frame_seq`

## Requirements
- R1: After synchronous reset, dma_req is 0, overrun is 0 and the local bus follows the host inputs. The map contents are not cleared by reset.
- R2: A write with map_wr=1 stores map_wr_item at entry map_wr_idx. Bit 15 of an entry is the end-of-frame flag and bits 14:0 are the local address.
- R3: A rising edge on the request line chosen by src_sel (0 = converter done, 1 = pacer, 2 = external pulse, 3 = trigger) raises dma_req on the following clock. Edges on unselected lines have no effect.
- R4: In a cycle where dma_req and dma_ack are both 1, lb_addr equals the address of the current entry. Exactly one strobe is active in that cycle: lb_rd when dir_to_mem=1 (device to memory), lb_wr when dir_to_mem=0.
- R5: In any cycle without an acknowledged transfer, lb_addr, lb_rd and lb_wr equal host_addr, host_rd and host_wr.
- R6: Each acknowledged transfer advances the entry pointer by one. A cycle without dma_ack leaves the pointer where it is.
- R7: After the entry with the end-of-frame flag is acknowledged, dma_req falls on the next clock and the next frame starts again at entry 0.
- R8: If no entry up to the last one (index 63) carries the flag, the frame ends after entry 63 is acknowledged.
- R9: A request edge while a frame is open, including the cycle of the final acknowledge, sets overrun. The flag stays set until reset. The edge neither starts a new frame nor disturbs the open one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr | input | 1 | Map entry write enable |
| map_wr_idx | input | 6 | Map entry index |
| map_wr_item | input | 16 | Entry: bit 15 end-of-frame, bits 14:0 local address |
| src_sel | input | 2 | Request source select |
| src_eoc | input | 1 | Converter done request line |
| src_pacer | input | 1 | Pacer clock request line |
| src_ext | input | 1 | External pulse request line |
| src_trig | input | 1 | Trigger circuit request line |
| dir_to_mem | input | 1 | 1 = device to memory, 0 = memory to device |
| dma_req | output | 1 | DMA request to host, high for the whole frame |
| dma_ack | input | 1 | DMA acknowledge, one byte per high cycle |
| host_addr | input | 15 | Host address for normal accesses |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| lb_addr | output | 15 | Local bus address |
| lb_rd | output | 1 | Local bus read strobe |
| lb_wr | output | 1 | Local bus write strobe |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The closing acknowledge of a frame and a new request edge can land in the same clock. In that cycle the sequencer is both shutting the frame and seeing a fresh request. The bench provokes this by raising the pacer line at the same negative edge as the last dma_ack. The result is judged correct only if dma_req drops on the next clock and overrun is set. A later clean edge must then start a frame at entry 0 again.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    localparam int MAP_DEPTH = 64;
    localparam int IDX_W     = $clog2(MAP_DEPTH);
    localparam int LADDR_W   = 15;
    localparam int ITEM_W    = LADDR_W + 1;
    localparam int NUM_SRC   = 4;
    localparam int SEL_W     = $clog2(NUM_SRC);

    typedef logic [LADDR_W-1:0] laddr_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        logic   eof;
        laddr_t addr;
    } map_item_t;

    typedef enum logic [SEL_W-1:0] {
        SRC_EOC   = 2'd0,
        SRC_PACER = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_TRIG  = 2'd3
    } src_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic   rd;
        logic   wr;
        laddr_t addr;
    } bus_cmd_t;

    function automatic map_item_t to_item(input logic [ITEM_W-1:0] raw);
        return map_item_t'(raw);
    endfunction

    function automatic logic is_last(input map_item_t it, input idx_t idx);
        return it.eof || (idx == idx_t'(MAP_DEPTH - 1));
    endfunction
endpackage

// File: rtl/dfs_req_sel.sv
module dfs_req_sel
    import dfs_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         src_in,
    input  logic [$clog2(NSRC)-1:0] sel,
    output logic                    start
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] edge_v;

    for (genvar g = 0; g < NSRC; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b0;
            else     prev_q[g] <= src_in[g];
        end
        assign edge_v[g] = src_in[g] & ~prev_q[g];
    end

    assign start = edge_v[sel];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start |=> !start) else $error("edge held two cycles"); // R3
endmodule

// File: rtl/dfs_map.sv
module dfs_map
    import dfs_pkg::*;
#(
    parameter int DEPTH = MAP_DEPTH
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [ITEM_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output map_item_t                rd_item
);
    logic [ITEM_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_item = to_item(mem_q[rd_idx]);
endmodule

// File: rtl/dfs_seq.sv
module dfs_seq
    import dfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      dma_ack,
    input  map_item_t item,
    output idx_t      idx,
    output logic      dma_req,
    output logic      xfer,
    output logic      overrun
);
    seq_state_e state_q;
    idx_t       idx_q;
    logic       ovr_q;
    logic       last;

    assign last = is_last(item, idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (start && state_q == ST_RUN) ovr_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        idx_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (dma_ack) begin
                        if (last) begin
                            state_q <= ST_IDLE;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idx     = idx_q;
    assign dma_req = (state_q == ST_RUN);
    assign xfer    = dma_req & dma_ack;
    assign overrun = ovr_q;

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_ack) |=> $stable(idx_q)) else $error("idx moved"); // R6
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfer && !last) |=> (idx_q == $past(idx_q) + 1'b1)) else $error("idx step"); // R6
    AST_FRAME_END: assert property (@(posedge clk) disable iff (rst)
        (xfer && last) |=> (!dma_req && idx_q == '0)) else $error("frame end"); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun) else $error("overrun cleared"); // R9
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (start && dma_req) |=> overrun) else $error("overrun missed"); // R9
endmodule

// File: rtl/dfs_bus_mux.sv
module dfs_bus_mux
    import dfs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     xfer,
    input  logic     dir_to_mem,
    input  laddr_t   item_addr,
    input  bus_cmd_t host_cmd,
    output bus_cmd_t lb_cmd
);
    bus_cmd_t dma_cmd;

    always_comb begin
        dma_cmd.addr = item_addr;
        dma_cmd.rd   = dir_to_mem;
        dma_cmd.wr   = ~dir_to_mem;
        lb_cmd       = xfer ? dma_cmd : host_cmd;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        xfer |-> (lb_cmd.rd ^ lb_cmd.wr)) else $error("strobe"); // R4
endmodule

// File: rtl/dfs_frame_seq.sv
module dfs_frame_seq
    import dfs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                map_wr,
    input  logic [IDX_W-1:0]    map_wr_idx,
    input  logic [ITEM_W-1:0]   map_wr_item,
    input  logic [SEL_W-1:0]    src_sel,
    input  logic                src_eoc,
    input  logic                src_pacer,
    input  logic                src_ext,
    input  logic                src_trig,
    input  logic                dir_to_mem,
    output logic                dma_req,
    input  logic                dma_ack,
    input  logic [LADDR_W-1:0]  host_addr,
    input  logic                host_rd,
    input  logic                host_wr,
    output logic [LADDR_W-1:0]  lb_addr,
    output logic                lb_rd,
    output logic                lb_wr,
    output logic                overrun
);
    logic      start;
    logic      xfer;
    idx_t      cur_idx;
    map_item_t cur_item;
    bus_cmd_t  host_cmd;
    bus_cmd_t  lb_cmd;
    logic [NUM_SRC-1:0] src_vec;

    always_comb begin
        src_vec[SRC_EOC]   = src_eoc;
        src_vec[SRC_PACER] = src_pacer;
        src_vec[SRC_EXT]   = src_ext;
        src_vec[SRC_TRIG]  = src_trig;
    end

    dfs_req_sel #(.NSRC(NUM_SRC)) u_sel (
        .clk(clk), .rst(rst), .src_in(src_vec), .sel(src_sel), .start(start)
    );

    dfs_map #(.DEPTH(MAP_DEPTH)) u_map (
        .clk(clk), .wr_en(map_wr), .wr_idx(map_wr_idx), .wr_data(map_wr_item),
        .rd_idx(cur_idx), .rd_item(cur_item)
    );

    dfs_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .dma_ack(dma_ack), .item(cur_item),
        .idx(cur_idx), .dma_req(dma_req), .xfer(xfer), .overrun(overrun)
    );

    assign host_cmd = '{rd: host_rd, wr: host_wr, addr: host_addr};

    dfs_bus_mux u_mux (
        .clk(clk), .rst(rst), .xfer(xfer), .dir_to_mem(dir_to_mem),
        .item_addr(cur_item.addr), .host_cmd(host_cmd), .lb_cmd(lb_cmd)
    );

    assign lb_addr = lb_cmd.addr;
    assign lb_rd   = lb_cmd.rd;
    assign lb_wr   = lb_cmd.wr;

    AST_HOST_PASS: assert property (@(posedge clk) disable iff (rst)
        !dma_req |-> (lb_addr == host_addr)) else $error("host pass"); // R5
endmodule

// File: tb/sim_dfs_frame_seq.sv
module sim_dfs_frame_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        map_wr;
    logic [5:0]  map_wr_idx;
    logic [15:0] map_wr_item;
    logic [1:0]  src_sel;
    logic        src_eoc, src_pacer, src_ext, src_trig;
    logic        dir_to_mem;
    logic        dma_req;
    logic        dma_ack;
    logic [14:0] host_addr;
    logic        host_rd, host_wr;
    logic [14:0] lb_addr;
    logic        lb_rd, lb_wr;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dfs_frame_seq u0 (
        .clk(clk), .rst(rst), .map_wr(map_wr), .map_wr_idx(map_wr_idx),
        .map_wr_item(map_wr_item), .src_sel(src_sel), .src_eoc(src_eoc),
        .src_pacer(src_pacer), .src_ext(src_ext), .src_trig(src_trig),
        .dir_to_mem(dir_to_mem), .dma_req(dma_req), .dma_ack(dma_ack),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .lb_addr(lb_addr), .lb_rd(lb_rd), .lb_wr(lb_wr), .overrun(overrun)
    );

    localparam int NTBL = 5;
    localparam logic [15:0] FRAME_TBL [NTBL] = '{
        16'h0123, 16'h2456, 16'h0007, 16'h7ABC, 16'h8311
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_item(input int idx, input logic [15:0] val);
        @(negedge clk);
        map_wr = 1'b1; map_wr_idx = 6'(idx); map_wr_item = val;
        @(negedge clk);
        map_wr = 1'b0;
    endtask

    task automatic pulse_pacer();
        @(negedge clk); src_pacer = 1'b1;
        @(negedge clk); src_pacer = 1'b0;
    endtask

    task automatic ack_one(input logic [14:0] exp_addr, input bit to_mem, input string tag);
        @(negedge clk);
        dma_ack = 1'b1;
        #1;
        chk(lb_addr == exp_addr, tag, lb_addr, exp_addr);
        chk((lb_rd == to_mem) && (lb_wr == !to_mem), "R4 strobe", {lb_rd, lb_wr}, {to_mem, !to_mem});
        @(posedge clk); #1;
        dma_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        map_wr = 0; map_wr_idx = 0; map_wr_item = 0;
        src_sel = 2'd1; src_eoc = 0; src_pacer = 0; src_ext = 0; src_trig = 0;
        dir_to_mem = 1; dma_ack = 0; host_addr = 15'h1555; host_rd = 1; host_wr = 0;
        do_reset();
        #1;
        // R1 reset state
        chk(dma_req == 0, "R1 dma_req", dma_req, 0);
        chk(overrun == 0, "R1 overrun", overrun, 0);
        chk(lb_addr == 15'h1555 && lb_rd && !lb_wr, "R1 passthrough", lb_addr, 15'h1555);

        // R2 program frame from table
        for (int i = 0; i < NTBL; i++) write_item(i, FRAME_TBL[i]);

        // R3 unselected source ignored
        @(negedge clk); src_ext = 1'b1;
        @(negedge clk); src_ext = 1'b0;
        @(negedge clk); #1;
        chk(dma_req == 0, "R3 unselected ignored", dma_req, 0);

        // R3 selected source starts frame
        pulse_pacer(); #1;
        chk(dma_req == 1, "R3 dma_req rise", dma_req, 1);

        // R5 passthrough while frame open but no ack; R6 hold
        host_addr = 15'h0AAA; host_rd = 0; host_wr = 1; #1;
        chk(lb_addr == 15'h0AAA && lb_wr && !lb_rd, "R5 host during frame", lb_addr, 15'h0AAA);
        repeat (3) @(negedge clk);

        // walk the table: R2/R4/R6
        for (int i = 0; i < NTBL; i++) begin
            ack_one(FRAME_TBL[i][14:0], 1'b1, "R2 R4 R6 item addr");
            if (i < NTBL - 1) begin
                #1;
                chk(dma_req == 1, "R6 frame continues", dma_req, 1);
                @(negedge clk); #1;
                chk(lb_addr == 15'h0AAA, "R5 host between acks", lb_addr, 15'h0AAA);
            end
        end
        @(negedge clk); #1;
        chk(dma_req == 0, "R7 dma_req falls at eof", dma_req, 0);
        chk(overrun == 0, "R9 no overrun", overrun, 0);

        // R7 second frame restarts at item 0, other direction
        dir_to_mem = 0;
        src_sel = 2'd3;
        @(negedge clk); src_trig = 1'b1;
        @(negedge clk); src_trig = 1'b0; #1;
        chk(dma_req == 1, "R3 trigger source", dma_req, 1);
        ack_one(FRAME_TBL[0][14:0], 1'b0, "R7 restart item0");
        ack_one(FRAME_TBL[1][14:0], 1'b0, "R7 item1");

        // R9 request mid-frame
        src_sel = 2'd3;
        @(negedge clk); src_trig = 1'b1;
        @(negedge clk); src_trig = 1'b0; #1;
        chk(overrun == 1, "R9 overrun set", overrun, 1);
        ack_one(FRAME_TBL[2][14:0], 1'b0, "R9 frame undisturbed");
        ack_one(FRAME_TBL[3][14:0], 1'b0, "R9 item3");
        ack_one(FRAME_TBL[4][14:0], 1'b0, "R9 item4");
        @(negedge clk); #1;
        chk(dma_req == 0, "R9 no extra frame", dma_req, 0);
        chk(overrun == 1, "R9 sticky", overrun, 1);

        // R9 request in final-ack cycle
        do_reset(); #1;
        chk(overrun == 0, "R1 overrun cleared", overrun, 0);
        src_sel = 2'd1; dir_to_mem = 1;
        pulse_pacer();
        for (int i = 0; i < NTBL - 1; i++) ack_one(FRAME_TBL[i][14:0], 1'b1, "R6 item");
        @(negedge clk);
        dma_ack = 1'b1; src_pacer = 1'b1;
        @(posedge clk); #1;
        dma_ack = 1'b0;
        @(negedge clk); src_pacer = 1'b0; #1;
        chk(dma_req == 0, "R9 collide frame closed", dma_req, 0);
        chk(overrun == 1, "R9 collide overrun", overrun, 1);
        pulse_pacer(); #1;
        chk(dma_req == 1, "R7 new frame after collide", dma_req, 1);
        ack_one(FRAME_TBL[0][14:0], 1'b1, "R7 item0 after collide");
        do_reset();

        // R8 no eof anywhere
        for (int i = 0; i < 64; i++) write_item(i, {1'b0, 15'((i * 7 + 3) & 16'h7FFF)});
        pulse_pacer();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); #1;
            chk(dma_req == 1, "R8 still open", dma_req, 1);
            ack_one(15'((i * 7 + 3) & 16'h7FFF), 1'b1, "R8 item addr");
        end
        @(negedge clk); #1;
        chk(dma_req == 0, "R8 ends after 63", dma_req, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule